// File: doc/BRIEF.md
# Indexed Register Access Port

This block gives a host a two-word window onto a large bank of per-channel registers. The host first writes a selector word holding a register index and a channel number. Each later access to the second word reads or writes the 32-bit register that the selector names. The bank covers 128 register indices for each of four channels. Most locations are plain read/write storage. A few locations are fixed: one index reads a constant, one index reads a constant only on channel 0, and one reads zero.

The channel half and the index half of the selector word can each be written without changing the other. Software can therefore step through channels while keeping the index, or step through indices while keeping the channel, with a single partial write. The host side is a single-beat request channel with byte enables. Read data comes back on a response strobe one cycle after the request.

The request channel uses valid/ready. Ready is held high, so every request with valid high is taken in the cycle it is presented. The response channel has no ready. The host must accept each response in the cycle it appears. Responses follow reads in order, one per read.

Top module: `idx_reg_port`

## Requirements
- R1: After reset the selector word reads 0, and register indices 0x00 to 0x3f read 0 on every channel.
- R2: The selector word keeps the channel number in bits [1:0] and the register index in bits [22:16]. All other bits read back as 0.
- R3: A selector write updates the channel field only when byte enable 0 is set, and the index field only when byte enable 2 is set. A field whose byte is not enabled keeps its value.
- R4: A data-word write stores into the register named by the current selector, on its channel only. Other channels at the same index keep their contents.
- R5: A data-word write changes only the bytes whose byte enable bit is set (bit n covers data bits [8n+7:8n]).
- R6: Index 0x74 reads 0x00000071 on channel 0 and 0 on channels 1 to 3. Writes to index 0x74 have no effect.
- R7: Index 0x6b reads 0x00400000 on every channel and index 0x73 reads 0 on every channel. Writes to either index have no effect.
- R8: req_rdy is always high. Every read request gives exactly one rsp_vld pulse in the next cycle, carrying the data. Write requests give no response.
- R9: A data-word access uses the selector value as it stood before that access. A selector write followed in the very next cycle by a data write stores into the new target.
- R10: Host offsets other than 0x0 (selector) and 0x4 (data) are ignored on write and read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_vld | input | 1 | Host request valid |
| req_rdy | output | 1 | Host request ready (always 1) |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | HOST_AW | Host byte offset (0x0 selector, 0x4 data) |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for writes |
| rsp_vld | output | 1 | Read response valid, one cycle after a read |
| rsp_rdata | output | 32 | Read response data |

## Verification
The assertions assume that the host changes request signals only between clock edges, and that req_vld stays low while reset is active. The assertions do not model back-pressure on responses: they take every response as consumed in the cycle it appears. The directed tasks drive one request at a time on the falling edge. The only back-to-back traffic is the selector-then-data pair, which stays within these assumptions. No task drives a value onto req_be or req_addr that the requirements leave undefined.

// File: rtl/idx_reg_pkg.sv
package idx_reg_pkg;
  // Field placement inside the selector word
  localparam int unsigned SEL_IDX_LSB = 16;

  // Host offsets of the two window words
  localparam int unsigned HOFF_SEL  = 0;
  localparam int unsigned HOFF_DATA = 4;

  // Fixed locations of the indexed space
  localparam int unsigned IDX_VERSION  = 'h74;
  localparam int unsigned IDX_FIXED_A  = 'h6b;
  localparam int unsigned IDX_FIXED_B  = 'h73;
  localparam logic [31:0] VAL_VERSION  = 32'h0000_0071;
  localparam logic [31:0] VAL_FIXED_A  = 32'h0040_0000;
  localparam logic [31:0] VAL_FIXED_B  = 32'h0000_0000;

  typedef enum logic [1:0] {
    LOC_STORE,
    LOC_FIXED,
    LOC_CH0_ONLY
  } loc_kind_e;

  function automatic loc_kind_e loc_kind(input int unsigned idx);
    if (idx == IDX_VERSION)                         return LOC_CH0_ONLY;
    else if (idx == IDX_FIXED_A || idx == IDX_FIXED_B) return LOC_FIXED;
    else                                            return LOC_STORE;
  endfunction
endpackage

// File: rtl/idx_sel_reg.sv
module idx_sel_reg #(
  parameter int unsigned CHW = 2,
  parameter int unsigned RAW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           be_ch,
  input  logic           be_idx,
  input  logic [CHW-1:0] wr_ch,
  input  logic [RAW-1:0] wr_idx,
  output logic [CHW-1:0] sel_ch,
  output logic [RAW-1:0] sel_idx,
  output logic [31:0]    sel_word
);
  import idx_reg_pkg::*;

  // Each half has its own enable so the two fields update independently
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_ch  <= '0;
      sel_idx <= '0;
    end else if (wr_en) begin
      if (be_ch)  sel_ch  <= wr_ch;
      if (be_idx) sel_idx <= wr_idx;
    end
  end

  always_comb begin
    sel_word                       = '0;
    sel_word[CHW-1:0]              = sel_ch;
    sel_word[SEL_IDX_LSB +: RAW]   = sel_idx;
  end
endmodule

// File: rtl/idx_bank.sv
module idx_bank #(
  parameter int unsigned NCH = 4,
  parameter int unsigned NREG = 128,
  localparam int unsigned CHW = $clog2(NCH),
  localparam int unsigned RAW = $clog2(NREG),
  localparam int unsigned DW  = 32,
  localparam int unsigned BEW = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [BEW-1:0] wr_be,
  input  logic [DW-1:0]  wr_data,
  input  logic [CHW-1:0] sel_ch,
  input  logic [RAW-1:0] sel_idx,
  output logic [DW-1:0]  rd_data
);
  import idx_reg_pkg::*;

  loc_kind_e          kind;
  logic               store_wr;
  logic [DW-1:0]      ch_rd [NCH];

  assign kind     = loc_kind(int'(sel_idx));
  assign store_wr = wr_en && (kind == LOC_STORE);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] mem_q [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
      end else if (store_wr && sel_ch == CHW'(c)) begin
        for (int b = 0; b < BEW; b++)
          if (wr_be[b]) mem_q[sel_idx][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
    end

    assign ch_rd[c] = mem_q[sel_idx];
  end

  always_comb begin
    unique case (kind)
      LOC_CH0_ONLY: rd_data = (sel_ch == '0) ? VAL_VERSION : '0;
      LOC_FIXED:    rd_data = (int'(sel_idx) == IDX_FIXED_A) ? VAL_FIXED_A : VAL_FIXED_B;
      default:      rd_data = ch_rd[sel_ch];
    endcase
  end
endmodule

// File: rtl/idx_reg_port.sv
module idx_reg_port #(
  parameter int unsigned NCH = 4,
  parameter int unsigned NREG = 128,
  parameter int unsigned HOST_AW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_vld,
  output logic               req_rdy,
  input  logic               req_wr,
  input  logic [HOST_AW-1:0] req_addr,
  input  logic [31:0]        req_wdata,
  input  logic [3:0]         req_be,
  output logic               rsp_vld,
  output logic [31:0]        rsp_rdata
);
  import idx_reg_pkg::*;

  localparam int unsigned CHW = $clog2(NCH);
  localparam int unsigned RAW = $clog2(NREG);

  logic           hit_sel, hit_data, rd_acc;
  logic [CHW-1:0] ptr_ch;
  logic [RAW-1:0] ptr_addr;
  logic [31:0]    sel_word, bank_rd, rd_mux;

  assign req_rdy  = 1'b1;
  assign hit_sel  = (int'(req_addr) == HOFF_SEL);
  assign hit_data = (int'(req_addr) == HOFF_DATA);
  assign rd_acc   = req_vld && !req_wr;

  idx_sel_reg #(.CHW(CHW), .RAW(RAW)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (req_vld && req_wr && hit_sel),
    .be_ch    (req_be[0]),
    .be_idx   (req_be[2]),
    .wr_ch    (req_wdata[CHW-1:0]),
    .wr_idx   (req_wdata[SEL_IDX_LSB +: RAW]),
    .sel_ch   (ptr_ch),
    .sel_idx  (ptr_addr),
    .sel_word (sel_word)
  );

  idx_bank #(.NCH(NCH), .NREG(NREG)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (req_vld && req_wr && hit_data),
    .wr_be   (req_be),
    .wr_data (req_wdata),
    .sel_ch  (ptr_ch),
    .sel_idx (ptr_addr),
    .rd_data (bank_rd)
  );

  always_comb begin
    if (hit_sel)       rd_mux = sel_word;
    else if (hit_data) rd_mux = bank_rd;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_vld <= rd_acc;
      if (rd_acc) rsp_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/idx_reg_port_chk.sv
module idx_reg_port_chk #(
  parameter int unsigned HOST_AW = 4,
  parameter int unsigned CHW = 2,
  parameter int unsigned RAW = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_vld,
  input logic               req_wr,
  input logic [HOST_AW-1:0] req_addr,
  input logic [3:0]         req_be,
  input logic               rsp_vld,
  input logic [31:0]        rsp_rdata,
  input logic [CHW-1:0]     ptr_ch,
  input logic [RAW-1:0]     ptr_addr
);
  logic sel_wr, data_rd, any_rd, odd_rd;
  assign sel_wr  = req_vld && req_wr && (req_addr == HOST_AW'(0));
  assign any_rd  = req_vld && !req_wr;
  assign data_rd = any_rd && (req_addr == HOST_AW'(4));
  assign odd_rd  = any_rd && (req_addr != HOST_AW'(0)) && (req_addr != HOST_AW'(4));

  AST_RD_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n) any_rd |=> rsp_vld); // R8
  AST_NO_EXTRA_RSP: assert property (@(posedge clk) disable iff (!rst_n) !any_rd |=> !rsp_vld); // R8
  AST_CH_HELD: assert property (@(posedge clk) disable iff (!rst_n) (sel_wr && !req_be[0]) |=> $stable(ptr_ch)); // R3
  AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n) (sel_wr && !req_be[2]) |=> $stable(ptr_addr)); // R3
  AST_VERSION_CH0: assert property (@(posedge clk) disable iff (!rst_n) (data_rd && ptr_addr == RAW'('h74) && ptr_ch == '0) |=> rsp_rdata == 32'h0000_0071); // R6
  AST_FIXED_A: assert property (@(posedge clk) disable iff (!rst_n) (data_rd && ptr_addr == RAW'('h6b)) |=> rsp_rdata == 32'h0040_0000); // R7
  AST_ODD_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n) odd_rd |=> rsp_rdata == '0); // R10
endmodule

bind idx_reg_port idx_reg_port_chk #(.HOST_AW(HOST_AW), .CHW(CHW), .RAW(RAW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_wr    (req_wr),
  .req_addr  (req_addr),
  .req_be    (req_be),
  .rsp_vld   (rsp_vld),
  .rsp_rdata (rsp_rdata),
  .ptr_ch    (ptr_ch),
  .ptr_addr  (ptr_addr)
);

// File: tb/idx_reg_port_bench.sv
module idx_reg_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0;
  logic        req_rdy;
  logic        req_wr = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_vld;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  idx_reg_port u_idx_reg_port (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_rdy(req_rdy),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] off, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    req_vld = 1'b1; req_wr = 1'b1; req_addr = off; req_wdata = d; req_be = be;
    @(negedge clk);
    req_vld = 1'b0; req_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [3:0] off, output logic [31:0] d, output logic v);
    @(negedge clk);
    req_vld = 1'b1; req_wr = 1'b0; req_addr = off;
    @(negedge clk);
    req_vld = 1'b0;
    d = rsp_rdata; v = rsp_vld;
  endtask

  task automatic set_sel(input int ch, input int idx);
    host_wr(4'h0, (32'(idx) << 16) | 32'(ch), 4'hf);
  endtask

  task automatic rd_at(input int ch, input int idx, output logic [31:0] d);
    logic v;
    set_sel(ch, idx);
    host_rd(4'h4, d, v);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic v;
    host_rd(4'h0, d, v);
    chk("R1 selector after reset", d, 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd_at(c, 'h00, d); chk("R1 idx 0x00 zero", d, 0);
      rd_at(c, 'h3f, d); chk("R1 idx 0x3f zero", d, 0);
    end
  endtask

  task automatic t_layout;
    logic [31:0] d; logic v;
    host_wr(4'h0, 32'hffff_ffff, 4'hf);
    host_rd(4'h0, d, v);
    chk("R2 selector field layout", d, 32'h007f_0003);
  endtask

  task automatic t_halves;
    logic [31:0] d; logic v;
    set_sel(2, 'h12);
    host_wr(4'h0, 32'hffff_0001, 4'b0011);
    host_rd(4'h0, d, v);
    chk("R3 channel-only write", d, 32'h0012_0001);
    host_wr(4'h0, 32'h0035_0003, 4'b1100);
    host_rd(4'h0, d, v);
    chk("R3 index-only write", d, 32'h0035_0001);
  endtask

  task automatic t_channels;
    logic [31:0] d;
    set_sel(0, 'h10); host_wr(4'h4, 32'haaaa_0000, 4'hf);
    set_sel(1, 'h10); host_wr(4'h4, 32'hbbbb_1111, 4'hf);
    set_sel(3, 'h50); host_wr(4'h4, 32'h5050_5050, 4'hf);
    rd_at(0, 'h10, d); chk("R4 ch0 idx 0x10", d, 32'haaaa_0000);
    rd_at(1, 'h10, d); chk("R4 ch1 idx 0x10", d, 32'hbbbb_1111);
    rd_at(2, 'h10, d); chk("R4 ch2 untouched", d, 32'h0);
    rd_at(3, 'h50, d); chk("R4 ch3 idx 0x50", d, 32'h5050_5050);
  endtask

  task automatic t_bytes;
    logic [31:0] d;
    set_sel(2, 'h05); host_wr(4'h4, 32'h1122_3344, 4'hf);
    host_wr(4'h4, 32'haabb_ccdd, 4'b0101);
    rd_at(2, 'h05, d); chk("R5 byte enables 0101", d, 32'h11bb_33dd);
    set_sel(2, 'h05); host_wr(4'h4, 32'h9900_0000, 4'b1000);
    rd_at(2, 'h05, d); chk("R5 byte enable 1000", d, 32'h99bb_33dd);
  endtask

  task automatic t_version;
    logic [31:0] d;
    rd_at(0, 'h74, d); chk("R6 ch0 constant", d, 32'h71);
    host_wr(4'h4, 32'hdead_beef, 4'hf);
    rd_at(0, 'h74, d); chk("R6 write ignored", d, 32'h71);
    set_sel(2, 'h74); host_wr(4'h4, 32'hdead_beef, 4'hf);
    rd_at(2, 'h74, d); chk("R6 ch2 reads zero", d, 32'h0);
  endtask

  task automatic t_fixed;
    logic [31:0] d;
    rd_at(0, 'h6b, d); chk("R7 0x6b ch0", d, 32'h0040_0000);
    host_wr(4'h4, 32'h1234_5678, 4'hf);
    rd_at(3, 'h6b, d); chk("R7 0x6b ch3", d, 32'h0040_0000);
    rd_at(0, 'h6b, d); chk("R7 0x6b write ignored", d, 32'h0040_0000);
    set_sel(1, 'h73); host_wr(4'h4, 32'hffff_ffff, 4'hf);
    rd_at(1, 'h73, d); chk("R7 0x73 write ignored", d, 32'h0);
  endtask

  task automatic t_timing;
    logic [31:0] d; logic v;
    chk("R8 ready high", 32'(req_rdy), 1);
    host_rd(4'h0, d, v);
    chk("R8 response strobe", 32'(v), 1);
    @(negedge clk);
    chk("R8 single pulse", 32'(rsp_vld), 0);
    host_wr(4'h0, 32'h0001_0001, 4'hf);
    chk("R8 no response on write", 32'(rsp_vld), 0);
  endtask

  task automatic t_b2b;
    logic [31:0] d;
    set_sel(0, 'h11);
    @(negedge clk);
    req_vld = 1'b1; req_wr = 1'b1; req_addr = 4'h0; req_wdata = 32'h0022_0003; req_be = 4'hf;
    @(negedge clk);
    req_addr = 4'h4; req_wdata = 32'hcafe_f00d;
    @(negedge clk);
    req_vld = 1'b0; req_wr = 1'b0;
    rd_at(3, 'h22, d); chk("R9 new target written", d, 32'hcafe_f00d);
    rd_at(0, 'h11, d); chk("R9 old target untouched", d, 32'h0);
  endtask

  task automatic t_badoff;
    logic [31:0] d; logic v;
    set_sel(1, 'h10);
    host_wr(4'h8, 32'hffff_ffff, 4'hf);
    host_rd(4'h8, d, v);
    chk("R10 odd offset reads zero", d, 32'h0);
    host_rd(4'h0, d, v);
    chk("R10 selector unchanged", d, 32'h0010_0001);
    host_rd(4'h4, d, v);
    chk("R10 data unchanged", d, 32'hbbbb_1111);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_layout();
    t_halves();
    t_channels();
    t_bytes();
    t_version();
    t_fixed();
    t_timing();
    t_b2b();
    t_badoff();
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule